// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor's load/store port and a main-memory port and holds a small set of recently read doublewords. The processor issues one 64-bit load or store at a time, using a byte address that is a multiple of 8. It holds the request steady until the cache pulses `req_ready`. The cache has four 16-byte lines, so 64 bytes in total. Each address maps to exactly one line. A load that misses fetches the whole line from memory, installs it and then returns the requested doubleword.

Every store goes straight through to memory as a single doubleword write. A store that hits also updates the cached copy. A store that misses goes only to memory and leaves the line state as it was. A `resp_hit` flag is reported together with each completion, so a hit/miss trace of a program can be compared against a precomputed sequence.

Top module: `dc_wt_cache`

## Requirements
- R1: A synchronous active-high reset marks every line invalid, so the first load to any address after reset is reported as a miss. During reset, `req_ready`, `mem_rd_valid` and `mem_wr_valid` are low.
- R2: A load that misses raises `mem_rd_valid` with `mem_rd_addr` equal to the request address with bits [3:0] cleared. The returned line carries the doubleword at line offset 0 in bits [63:0] and the one at offset 8 in bits [127:64]. The load then completes with `resp_hit` low and `resp_rdata` equal to the doubleword selected by address bit [3].
- R3: After a line has been filled, loads to either doubleword of that line complete with `resp_hit` high, return the cached value and issue no memory read.
- R4: Address bits [5:4] select the line and bits [31:6] form the tag. A load whose index matches a valid line but whose tag differs is a miss and replaces that line, so a later load to the evicted address misses again.
- R5: A store that hits updates the cached doubleword, so a following load to that address hits and returns the stored value.
- R6: Every store, hit or miss, issues exactly one memory write, with `mem_wr_addr` equal to the request address and `mem_wr_data` equal to the store data.
- R7: A store that misses does not allocate: no memory read is issued, it completes with `resp_hit` low, and a later load to that address misses and returns the stored value from memory.
- R8: A store miss leaves the line already held at its index unchanged, so loads to that line still hit with their old contents.
- R9: `req_ready` is high for exactly one cycle per access, and `resp_hit` is high only in a cycle where `req_ready` is high.
- R10: A store completes only after memory has acknowledged its write (`mem_wr_ready` sampled high while `mem_wr_valid` is high).
- R11: Once raised, `mem_rd_valid` and `mem_wr_valid` stay high, with the address and data held stable, until acknowledged. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present, held until `req_ready` |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address, 8-byte aligned |
| req_wdata | input | 64 | Store data |
| req_ready | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 64 | Load data, valid with `req_ready` |
| resp_hit | output | 1 | Hit flag, valid with `req_ready` |
| mem_rd_valid | output | 1 | Line read request |
| mem_rd_addr | output | 32 | Line-aligned read address |
| mem_rd_ready | input | 1 | Line read acknowledge, line data present |
| mem_rd_line | input | 128 | Line read data |
| mem_wr_valid | output | 1 | Doubleword write request |
| mem_wr_addr | output | 32 | Write address |
| mem_wr_data | output | 64 | Write data |
| mem_wr_ready | input | 1 | Write acknowledge |

## Verification
The main stimulus is a doubleword scaling loop. It repeatedly loads a fixed factor from address 0, loads an element, and stores the element back, over addresses 16 to 72. The expected hit/miss trace separates cold misses, hits in the second half of a filled line, and the conflict that appears when address 64 evicts the factor's line so that address 0 misses again. Directed follow-ups then issue a store miss into an index held by another tag, which tells no-write-allocate apart from allocate and from corruption of the resident line. A store hit followed by a load checks that the cached copy is updated. A reset followed by a reload checks that reset clears all lines and that memory received every write-through.

// File: rtl/dc_pkg.sv
package dc_pkg;

    localparam int ADDR_W = 32;
    localparam int DW     = 64;
    localparam int WORDS  = 2;
    localparam int LINES  = 4;

    localparam int OFF_W  = $clog2(DW / 8);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - OFF_W;
    localparam int LINE_W = DW * WORDS;

    typedef logic [DW-1:0]     dword_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WSEL_W-1:0] wsel_t;

    typedef struct packed {
        tag_t               tag;
        idx_t               idx;
        wsel_t              wsel;
        logic [OFF_W-1:0]   off;
    } dc_addr_t;

    typedef struct packed {
        logic     write;
        dc_addr_t addr;
        dword_t   wdata;
    } dc_req_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_WRITE,
        ST_DONE
    } dc_state_e;

    function automatic dc_addr_t line_base(input dc_addr_t a);
        dc_addr_t b;
        b      = a;
        b.wsel = '0;
        b.off  = '0;
        return b;
    endfunction

    function automatic dword_t pick_word(input line_t l, input wsel_t s);
        return l[s*DW +: DW];
    endfunction

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store
    import dc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t rd_idx,
    output logic rd_valid,
    output tag_t rd_tag,
    input  logic wr_en,
    input  idx_t wr_idx,
    input  tag_t wr_tag
);

    logic valid_q [LINES];
    tag_t tag_q   [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
            end else if (wr_en && wr_idx == idx_t'(g)) begin
                valid_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == idx_t'(g)) begin
                tag_q[g] <= wr_tag;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store
    import dc_pkg::*;
(
    input  logic   clk,
    input  idx_t   rd_idx,
    input  wsel_t  rd_wsel,
    output dword_t rd_word,
    input  logic   fill_en,
    input  idx_t   fill_idx,
    input  line_t  fill_line,
    input  logic   upd_en,
    input  idx_t   upd_idx,
    input  wsel_t  upd_wsel,
    input  dword_t upd_word
);

    dword_t word_q [LINES][WORDS];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (fill_en && fill_idx == idx_t'(g)) begin
                    word_q[g][w] <= fill_line[w*DW +: DW];
                end else if (upd_en && upd_idx == idx_t'(g) && upd_wsel == wsel_t'(w)) begin
                    word_q[g][w] <= upd_word;
                end
            end
        end
    end

    assign rd_word = word_q[rd_idx][rd_wsel];

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
    import dc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   req_write,
    input  logic   lookup_hit,
    input  dword_t hit_word,
    input  dword_t fill_word,
    input  logic   mem_rd_ready,
    input  logic   mem_wr_ready,
    output logic   accept,
    output logic   fill_en,
    output logic   upd_en,
    output logic   req_ready,
    output logic   resp_hit,
    output dword_t resp_rdata,
    output logic   mem_rd_valid,
    output logic   mem_wr_valid
);

    dc_state_e state_q;
    logic      hit_q;
    dword_t    rdata_q;

    always_comb begin
        accept       = (state_q == ST_IDLE) && req_valid;
        fill_en      = (state_q == ST_FILL) && mem_rd_ready;
        upd_en       = accept && req_write && lookup_hit;
        req_ready    = (state_q == ST_DONE);
        resp_hit     = (state_q == ST_DONE) && hit_q;
        resp_rdata   = rdata_q;
        mem_rd_valid = (state_q == ST_FILL);
        mem_wr_valid = (state_q == ST_WRITE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hit_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        hit_q <= lookup_hit;
                        if (req_write) begin
                            state_q <= ST_WRITE;
                        end else if (lookup_hit) begin
                            rdata_q <= hit_word;
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_rd_ready) begin
                        rdata_q <= fill_word;
                        state_q <= ST_DONE;
                    end
                end
                ST_WRITE: begin
                    if (mem_wr_ready) begin
                        state_q <= ST_DONE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/dc_wt_cache.sv
module dc_wt_cache
    import dc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ready,
    output logic [DW-1:0]     resp_rdata,
    output logic              resp_hit,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic [LINE_W-1:0] mem_rd_line,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DW-1:0]     mem_wr_data,
    input  logic              mem_wr_ready
);

    dc_addr_t cur_addr;
    dc_req_t  req_q;
    logic     line_valid;
    tag_t     line_tag;
    logic     lookup_hit;
    dword_t   hit_word;
    dword_t   fill_word;
    logic     accept;
    logic     fill_en;
    logic     upd_en;

    assign cur_addr   = dc_addr_t'(req_addr);
    assign lookup_hit = line_valid && (line_tag == cur_addr.tag);
    assign fill_word  = pick_word(line_t'(mem_rd_line), req_q.addr.wsel);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.write <= req_write;
            req_q.addr  <= cur_addr;
            req_q.wdata <= req_wdata;
        end
    end

    dc_tag_store u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (cur_addr.idx),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .wr_en    (fill_en),
        .wr_idx   (req_q.addr.idx),
        .wr_tag   (req_q.addr.tag)
    );

    dc_data_store u_data (
        .clk       (clk),
        .rd_idx    (cur_addr.idx),
        .rd_wsel   (cur_addr.wsel),
        .rd_word   (hit_word),
        .fill_en   (fill_en),
        .fill_idx  (req_q.addr.idx),
        .fill_line (line_t'(mem_rd_line)),
        .upd_en    (upd_en),
        .upd_idx   (cur_addr.idx),
        .upd_wsel  (cur_addr.wsel),
        .upd_word  (req_wdata)
    );

    dc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .lookup_hit   (lookup_hit),
        .hit_word     (hit_word),
        .fill_word    (fill_word),
        .mem_rd_ready (mem_rd_ready),
        .mem_wr_ready (mem_wr_ready),
        .accept       (accept),
        .fill_en      (fill_en),
        .upd_en       (upd_en),
        .req_ready    (req_ready),
        .resp_hit     (resp_hit),
        .resp_rdata   (resp_rdata),
        .mem_rd_valid (mem_rd_valid),
        .mem_wr_valid (mem_wr_valid)
    );

    assign mem_rd_addr = ADDR_W'(line_base(req_q.addr));
    assign mem_wr_addr = ADDR_W'(req_q.addr);
    assign mem_wr_data = req_q.wdata;

endmodule

// File: rtl/dc_wt_cache_chk.sv
module dc_wt_cache_chk
    import dc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_write,
    input logic              req_ready,
    input logic              resp_hit,
    input logic              mem_rd_valid,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_ready,
    input logic              mem_wr_valid,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [DW-1:0]     mem_wr_data,
    input logic              mem_wr_ready
);

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    // R9
    hit_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
        resp_hit |-> req_ready);

    // R2
    line_aligned_rd_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> (mem_rd_addr[3:0] == 4'd0));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R11
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R11
    one_mem_op_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_valid && mem_wr_valid));

    // R10
    store_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_write) |-> $past(mem_wr_valid && mem_wr_ready));

    // R2
    miss_load_filled_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !req_write && !resp_hit) |-> $past(mem_rd_valid && mem_rd_ready));

    // R3
    hit_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready && resp_hit) |-> !$past(mem_rd_valid));

endmodule

bind dc_wt_cache dc_wt_cache_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_write    (req_write),
    .req_ready    (req_ready),
    .resp_hit     (resp_hit),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ready (mem_rd_ready),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_ready (mem_wr_ready)
);

// File: tb/dc_wt_cache_test.sv
module dc_wt_cache_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [63:0]  req_wdata = '0;
    logic         req_ready;
    logic [63:0]  resp_rdata;
    logic         resp_hit;
    logic         mem_rd_valid;
    logic [31:0]  mem_rd_addr;
    logic         mem_rd_ready = 1'b0;
    logic [127:0] mem_rd_line = '0;
    logic         mem_wr_valid;
    logic [31:0]  mem_wr_addr;
    logic [63:0]  mem_wr_data;
    logic         mem_wr_ready = 1'b0;

    int total = 0;
    int bad   = 0;

    logic [63:0] mem [16];
    int          rd_count = 0;
    int          wr_count = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] last_wr_addr = '0;
    logic [63:0] last_wr_data = '0;
    bit          wr_acked = 1'b0;

    always #4 clk = ~clk;

    dc_wt_cache uut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_ready    (req_ready),
        .resp_rdata   (resp_rdata),
        .resp_hit     (resp_hit),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_line  (mem_rd_line),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .mem_wr_ready (mem_wr_ready)
    );

    // loop trace: factor load, element load, element store
    localparam int N = 24;
    localparam bit TW [N] = '{0,0,1, 0,0,1, 0,0,1, 0,0,1, 0,0,1, 0,0,1, 0,0,1, 0,0,1};
    localparam int TA [N] = '{0,16,16, 0,24,24, 0,32,32, 0,40,40,
                              0,48,48, 0,56,56, 0,64,64, 0,72,72};
    localparam int TD [N] = '{0,0,28, 0,0,36, 0,0,20, 0,0,12, 0,0,4, 0,0,8, 0,0,20, 0,0,32};
    localparam bit TH [N] = '{0,0,1, 1,1,1, 1,0,1, 1,1,1, 1,0,1, 1,1,1, 1,0,1, 0,0,1};
    localparam int TR [N] = '{4,7,0, 4,9,0, 4,5,0, 4,3,0, 4,1,0, 4,2,0, 4,5,0, 4,8,0};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // memory responder: two-cycle wait, one-cycle acknowledge
    initial begin
        int rcnt = 0;
        int wcnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rd_ready) begin
                mem_rd_ready = 1'b0;
            end else if (mem_rd_valid) begin
                rcnt++;
                if (rcnt == 2) begin
                    rcnt = 0;
                    mem_rd_line  = {mem[mem_rd_addr[6:3] + 4'd1], mem[mem_rd_addr[6:3]]};
                    mem_rd_ready = 1'b1;
                    last_rd_addr = mem_rd_addr;
                    rd_count++;
                end
            end
            if (mem_wr_ready) begin
                mem_wr_ready = 1'b0;
            end else if (mem_wr_valid) begin
                wcnt++;
                if (wcnt == 2) begin
                    wcnt = 0;
                    mem[mem_wr_addr[6:3]] = mem_wr_data;
                    last_wr_addr = mem_wr_addr;
                    last_wr_data = mem_wr_data;
                    mem_wr_ready = 1'b1;
                    wr_acked     = 1'b1;
                    wr_count++;
                end
            end
        end
    end

    task automatic access(input bit wr, input int addr, input int wdata,
                          output logic [63:0] rdata, output logic hit);
        int waited = 0;
        @(negedge clk);
        wr_acked  = 1'b0;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 32'(addr);
        req_wdata = 64'(wdata);
        do begin
            @(negedge clk);
            waited++;
        end while (!req_ready && waited < 100);
        if (!req_ready) begin
            check("R9 completion timeout", 0, 1);
        end
        rdata = resp_rdata;
        hit   = resp_hit;
        // R10: a store may only complete after the memory acknowledged it
        if (wr) check("R10 store waited for ack", 64'(wr_acked), 1);
        req_valid = 1'b0;
        @(negedge clk);
        // R9: single-cycle completion pulse
        check("R9 ready pulse width", 64'(req_ready), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        logic        h;
        int          rc0;
        int          wc0;
        mem[0] = 4;  mem[1] = 1;  mem[2] = 7;   mem[3] = 9;
        mem[4] = 5;  mem[5] = 3;  mem[6] = 1;   mem[7] = 2;
        mem[8] = 5;  mem[9] = 8;  mem[10] = 7;  mem[11] = 3;
        for (int k = 12; k < 16; k++) mem[k] = 0;

        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check("R1 reset ready", 64'(req_ready), 0);
        check("R1 reset rd_valid", 64'(mem_rd_valid), 0);
        check("R1 reset wr_valid", 64'(mem_wr_valid), 0);
        rst = 1'b0;

        for (int i = 0; i < N; i++) begin
            string tagname;
            rc0 = rd_count;
            wc0 = wr_count;
            access(TW[i], TA[i], TD[i], rd, h);
            if (TW[i])       tagname = "R5 store hit";
            else if (i == 21) tagname = "R4 evicted reload";
            else if (TH[i])  tagname = "R3 load hit";
            else             tagname = "R2 load miss";
            check($sformatf("%s hit[%0d]", tagname, i), 64'(h), 64'(TH[i]));
            if (!TW[i]) begin
                check($sformatf("%s data[%0d]", tagname, i), rd, 64'(TR[i]));
                check($sformatf("R3 read count[%0d]", i), 64'(rd_count - rc0), TH[i] ? 0 : 1);
                if (!TH[i]) check($sformatf("R2 line addr[%0d]", i), 64'(last_rd_addr),
                                  64'(TA[i] & ~15));
            end
            check($sformatf("R6 write count[%0d]", i), 64'(wr_count - wc0), TW[i] ? 1 : 0);
            if (TW[i]) begin
                check($sformatf("R6 write addr[%0d]", i), 64'(last_wr_addr), 64'(TA[i]));
                check($sformatf("R6 write data[%0d]", i), last_wr_data, 64'(TD[i]));
            end
        end

        // R6: memory holds every written-through result
        check("R6 mem 16", mem[2], 28);
        check("R6 mem 40", mem[5], 12);
        check("R6 mem 72", mem[9], 32);

        // R7: store miss into index 0 (resident tag belongs to 64/72)
        rc0 = rd_count;
        wc0 = wr_count;
        access(1, 0, 99, rd, h);
        check("R7 store miss hit flag", 64'(h), 0);
        check("R7 store miss no read", 64'(rd_count - rc0), 0);
        check("R7 store miss writes", 64'(wr_count - wc0), 1);
        // R8: resident line untouched
        access(0, 64, 0, rd, h);
        check("R8 resident still hits", 64'(h), 1);
        check("R8 resident data", rd, 20);
        access(0, 72, 0, rd, h);
        check("R8 resident word1", rd, 32);
        // R7: no allocation, so this misses and sees memory
        access(0, 0, 0, rd, h);
        check("R7 later load misses", 64'(h), 0);
        check("R7 later load data", rd, 99);

        // R5: store hit then load
        access(1, 8, 55, rd, h);
        check("R5 store hit flag", 64'(h), 1);
        access(0, 8, 0, rd, h);
        check("R5 load after store hit", 64'(h), 1);
        check("R5 updated data", rd, 55);

        // R1: reset invalidates everything
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        access(0, 8, 0, rd, h);
        check("R1 miss after reset", 64'(h), 0);
        check("R6 memory kept store", rd, 55);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule